// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a byte-wide NOR flash. It watches write cycles on the host bus and decodes the multi-write unlock sequences that the host uses to request an operation. For each accepted command it raises a one-cycle strobe toward the embedded-algorithm engine. The strobe types are reset, identifier read, byte program, chip erase, sector erase, erase suspend and erase resume. The program target address and data, and the index of the sector to erase, are held on output buses next to the strobes.

The block also tracks the device mode: read, identifier read, programming, erasing, erase-suspended, and programming while suspended. The mode decides which commands are accepted. A running program ignores every write. A running sector erase accepts only a suspend request. A suspended erase accepts a resume or a byte-program sequence. The engine reports completion with a one-cycle done pulse. While it reports busy, any command that would start work is refused.

Write enable is sampled in the block's clock domain and is not used as a clock. The start of a bus write captures the address. The end of the write takes the data byte that was on the bus in the last cycle of the write and commits the write.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `mode` is 0 (read) and every strobe is low.
- R2: A bus write exists only while `ce_n`=0, `we_n`=0 and `oe_n`=1. The address is taken in the first cycle of the write. The data is taken in its last cycle. The write commits in the cycle after it ends. Cycles with `oe_n`=0 are not writes.
- R3: Every sequence opens with data AAh at address 555h, then data 55h at address 2AAh. Only address bits 10..0 are compared. Bits 19..11 are ignored.
- R4: Data F0h written at any address, whether as a single write or at any step of an unfinished sequence, pulses `rst_stb` and sets `mode` to 0. The one exception is the data write of a program command.
- R5: A third write of 90h at 555h pulses `id_stb` and sets `mode` to 1 (identifier read). Mode 1 persists until a reset command or a mismatching write.
- R6: A third write of A0h at 555h arms program. The next write pulses `prog_stb`, places its address on `prog_addr` and its data on `prog_data`, and sets `mode` to 2. From the suspended mode it sets `mode` to 5 instead.
- R7: After 80h at 555h, the host writes AAh at 555h and 55h at 2AAh. A sixth write of 10h at 555h pulses `chip_ers_stb`. A sixth write of 30h at any address pulses `sect_ers_stb`, with `ers_sector` set to address bits 19..16 of that write. Both set `mode` to 3.
- R8: In mode 0 or 1, a write that does not fit the sequence produces no strobe, restarts decoding and sets `mode` to 0. This includes a lone 30h or B0h.
- R9: In mode 2 or 5, every write is ignored. `eng_done` returns mode 2 to 0 and mode 5 to 4.
- R10: In mode 3 after a sector erase, a B0h write at any address pulses `susp_stb` and sets `mode` to 4. After a chip erase, B0h is ignored. All other writes in mode 3 are ignored. `eng_done` sets `mode` to 0.
- R11: In mode 4, a 30h write pulses `resume_stb` and sets `mode` to 3, after which a new suspend is accepted. A program sequence is accepted. Reset, identifier-read and erase sequences, and B0h, leave mode 4 unchanged with no strobe.
- R12: Each strobe lasts exactly one cycle, and at most one strobe is high in any cycle.
- R13: While `eng_busy`=1, a program, chip erase, sector erase or resume command gives no strobe and leaves `mode` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Bus chip enable, active low |
| we_n | input | 1 | Bus write enable, active low |
| oe_n | input | 1 | Bus output enable, active low |
| addr | input | 20 | Bus address |
| data | input | 8 | Bus write data |
| eng_busy | input | 1 | Engine is running an operation |
| eng_done | input | 1 | One-cycle pulse: engine finished its operation |
| rst_stb | output | 1 | Reset command strobe |
| id_stb | output | 1 | Identifier-read command strobe |
| prog_stb | output | 1 | Byte-program start strobe |
| chip_ers_stb | output | 1 | Chip-erase start strobe |
| sect_ers_stb | output | 1 | Sector-erase start strobe |
| susp_stb | output | 1 | Erase-suspend strobe |
| resume_stb | output | 1 | Erase-resume strobe |
| prog_addr | output | 20 | Program target address |
| prog_data | output | 8 | Program data byte |
| ers_sector | output | 4 | Sector index of the last sector erase |
| mode | output | 3 | 0 read, 1 id read, 2 program, 3 erase, 4 suspended, 5 program in suspend |

## Verification
The assertions assume that the bus pins are already synchronous to `clk`. They also assume that each write holds enable low for at least one cycle and is followed by at least one idle cycle. Under those two conditions, two commits can never fall in adjacent cycles. The assertions further assume that `eng_done` arrives only while an operation is outstanding. The bench drives every bus write from one task that holds enable low for two cycles and idles for two more. It pulses `eng_done` only after a strobe has put the block into a program or erase mode.

// File: rtl/flcmd_pkg.sv
package flcmd_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    MD_READ     = 3'd0,
    MD_IDRD     = 3'd1,
    MD_PGM      = 3'd2,
    MD_ERS      = 3'd3,
    MD_SUSP     = 3'd4,
    MD_SUSP_PGM = 3'd5
  } mode_t;

  typedef enum logic [3:0] {
    CM_NONE, CM_RESET, CM_ID, CM_PROG, CM_CHIP,
    CM_SECT, CM_SUSP, CM_RESUME, CM_BAD
  } cmd_t;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_U1, SQ_U2, SQ_PGM, SQ_E3, SQ_E4, SQ_E5
  } seq_t;

  localparam logic [DATA_W-1:0] K_UNLK1  = 8'hAA;
  localparam logic [DATA_W-1:0] K_UNLK2  = 8'h55;
  localparam logic [DATA_W-1:0] K_PROG   = 8'hA0;
  localparam logic [DATA_W-1:0] K_ESETUP = 8'h80;
  localparam logic [DATA_W-1:0] K_ID     = 8'h90;
  localparam logic [DATA_W-1:0] K_RESET  = 8'hF0;
  localparam logic [DATA_W-1:0] K_CHIP   = 8'h10;
  localparam logic [DATA_W-1:0] K_SECT   = 8'h30;
  localparam logic [DATA_W-1:0] K_SUSP   = 8'hB0;
endpackage

// File: rtl/flcmd_bus_sample.sv
module flcmd_bus_sample
  import flcmd_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              commit,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_data
);
  logic wr_now, wr_q;

  assign wr_now = ~ce_n & ~we_n & oe_n;
  assign commit = wr_q & ~wr_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q     <= 1'b0;
      cap_addr <= '0;
      cap_data <= '0;
    end else begin
      wr_q <= wr_now;
      if (wr_now && !wr_q) cap_addr <= addr;
      if (wr_now) cap_data <= data;
    end
  end
endmodule

// File: rtl/flcmd_unlock_seq.sv
module flcmd_unlock_seq
  import flcmd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CMP_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              seq_en,
  input  logic              prog_only,
  output cmd_t              cmd
);
  localparam logic [CMP_W-1:0] ADR_A = CMP_W'(12'h555);
  localparam logic [CMP_W-1:0] ADR_B = CMP_W'(12'h2AA);

  seq_t st, nxt;
  logic [CMP_W-1:0] low;
  logic at_a, at_b;

  assign low  = cap_addr[CMP_W-1:0];
  assign at_a = (low == ADR_A);
  assign at_b = (low == ADR_B);

  always_comb begin
    nxt = st;
    cmd = CM_NONE;
    if (commit) begin
      nxt = SQ_IDLE;
      if (!seq_en) begin
        cmd = (cap_data == K_SUSP) ? CM_SUSP : CM_NONE;
      end else if (st == SQ_PGM) begin
        cmd = CM_PROG;
      end else if (cap_data == K_RESET) begin
        cmd = CM_RESET;
      end else begin
        cmd = CM_BAD;
        case (st)
          SQ_IDLE: begin
            if (at_a && cap_data == K_UNLK1) begin nxt = SQ_U1; cmd = CM_NONE; end
            else if (cap_data == K_SECT) cmd = CM_RESUME;
            else if (cap_data == K_SUSP) cmd = CM_SUSP;
          end
          SQ_U1: if (at_b && cap_data == K_UNLK2) begin nxt = SQ_U2; cmd = CM_NONE; end
          SQ_U2: if (at_a) begin
            if (cap_data == K_PROG) begin nxt = SQ_PGM; cmd = CM_NONE; end
            else if (!prog_only && cap_data == K_ESETUP) begin nxt = SQ_E3; cmd = CM_NONE; end
            else if (!prog_only && cap_data == K_ID) cmd = CM_ID;
          end
          SQ_E3: if (at_a && cap_data == K_UNLK1) begin nxt = SQ_E4; cmd = CM_NONE; end
          SQ_E4: if (at_b && cap_data == K_UNLK2) begin nxt = SQ_E5; cmd = CM_NONE; end
          SQ_E5: begin
            if (at_a && cap_data == K_CHIP) cmd = CM_CHIP;
            else if (cap_data == K_SECT) cmd = CM_SECT;
          end
          default: ;
        endcase
      end
    end else if (!seq_en) begin
      nxt = SQ_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= SQ_IDLE;
    else        st <= nxt;
  end

  // R3
  unlock_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_U2 && $past(st) != SQ_U2) |-> $past(st) == SQ_U1);

  // R7
  erase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_E5 && $past(st) != SQ_E5) |-> $past(st) == SQ_E4);
endmodule

// File: rtl/flcmd_mode_ctl.sv
module flcmd_mode_ctl
  import flcmd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int SECT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_t              cmd,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              eng_busy,
  input  logic              eng_done,
  output logic              seq_en,
  output logic              prog_only,
  output logic              rst_stb,
  output logic              id_stb,
  output logic              prog_stb,
  output logic              chip_stb,
  output logic              sect_stb,
  output logic              susp_stb,
  output logic              resume_stb,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic [SECT_W-1:0] ers_sector,
  output mode_t             mode
);
  logic sect_q;

  assign seq_en    = (mode == MD_READ) || (mode == MD_IDRD) || (mode == MD_SUSP);
  assign prog_only = (mode == MD_SUSP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= MD_READ; sect_q <= 1'b0;
      rst_stb <= 1'b0; id_stb <= 1'b0; prog_stb <= 1'b0; chip_stb <= 1'b0;
      sect_stb <= 1'b0; susp_stb <= 1'b0; resume_stb <= 1'b0;
      prog_addr <= '0; prog_data <= '0; ers_sector <= '0;
    end else begin
      rst_stb <= 1'b0; id_stb <= 1'b0; prog_stb <= 1'b0; chip_stb <= 1'b0;
      sect_stb <= 1'b0; susp_stb <= 1'b0; resume_stb <= 1'b0;
      case (mode)
        MD_READ, MD_IDRD: begin
          case (cmd)
            CM_RESET: begin rst_stb <= 1'b1; mode <= MD_READ; end
            CM_ID:    begin id_stb  <= 1'b1; mode <= MD_IDRD; end
            CM_PROG: if (!eng_busy) begin
              prog_stb <= 1'b1; prog_addr <= cap_addr; prog_data <= cap_data; mode <= MD_PGM;
            end
            CM_CHIP: if (!eng_busy) begin
              chip_stb <= 1'b1; sect_q <= 1'b0; mode <= MD_ERS;
            end
            CM_SECT: if (!eng_busy) begin
              sect_stb <= 1'b1; sect_q <= 1'b1; mode <= MD_ERS;
              ers_sector <= cap_addr[ADDR_W-1 -: SECT_W];
            end
            CM_BAD, CM_SUSP, CM_RESUME: mode <= MD_READ;
            default: ;
          endcase
        end
        MD_PGM: if (eng_done) mode <= MD_READ;
        MD_ERS: begin
          if (eng_done) mode <= MD_READ;
          else if (cmd == CM_SUSP && sect_q) begin susp_stb <= 1'b1; mode <= MD_SUSP; end
        end
        MD_SUSP: begin
          if (cmd == CM_RESUME && !eng_busy) begin
            resume_stb <= 1'b1; mode <= MD_ERS;
          end else if (cmd == CM_PROG && !eng_busy) begin
            prog_stb <= 1'b1; prog_addr <= cap_addr; prog_data <= cap_data; mode <= MD_SUSP_PGM;
          end
        end
        MD_SUSP_PGM: if (eng_done) mode <= MD_SUSP;
        default: mode <= MD_READ;
      endcase
    end
  end

  // R12
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rst_stb, id_stb, prog_stb, chip_stb, sect_stb, susp_stb, resume_stb}));
  // R12
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_stb || id_stb || prog_stb || chip_stb || sect_stb || susp_stb || resume_stb) |=>
    !(rst_stb || id_stb || prog_stb || chip_stb || sect_stb || susp_stb || resume_stb));
  // R6
  prog_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_stb |-> (mode == MD_PGM || mode == MD_SUSP_PGM));
  // R9
  prog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_PGM && !eng_done) |=> mode == MD_PGM);
  // R10
  suspend_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    susp_stb |-> (mode == MD_SUSP && $past(mode) == MD_ERS));
  // R11
  resume_from_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_stb |-> $past(mode) == MD_SUSP);
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flcmd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CMP_W  = 11,
  parameter int SECT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  input  logic              eng_busy,
  input  logic              eng_done,
  output logic              rst_stb,
  output logic              id_stb,
  output logic              prog_stb,
  output logic              chip_ers_stb,
  output logic              sect_ers_stb,
  output logic              susp_stb,
  output logic              resume_stb,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_data,
  output logic [SECT_W-1:0] ers_sector,
  output logic [2:0]        mode
);
  logic              commit, seq_en, prog_only;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;
  cmd_t              cmd;
  mode_t             mode_w;

  flcmd_bus_sample #(.ADDR_W(ADDR_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .data(data), .commit(commit), .cap_addr(cap_addr), .cap_data(cap_data)
  );

  flcmd_unlock_seq #(.ADDR_W(ADDR_W), .CMP_W(CMP_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .commit(commit), .cap_addr(cap_addr), .cap_data(cap_data),
    .seq_en(seq_en), .prog_only(prog_only), .cmd(cmd)
  );

  flcmd_mode_ctl #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .cap_addr(cap_addr), .cap_data(cap_data),
    .eng_busy(eng_busy), .eng_done(eng_done), .seq_en(seq_en), .prog_only(prog_only),
    .rst_stb(rst_stb), .id_stb(id_stb), .prog_stb(prog_stb), .chip_stb(chip_ers_stb),
    .sect_stb(sect_ers_stb), .susp_stb(susp_stb), .resume_stb(resume_stb),
    .prog_addr(prog_addr), .prog_data(prog_data), .ers_sector(ers_sector), .mode(mode_w)
  );

  assign mode = mode_w;
endmodule

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [19:0] addr = '0;
  logic [7:0]  data = '0;
  logic eng_busy = 1'b0, eng_done = 1'b0;
  logic rst_stb, id_stb, prog_stb, chip_ers_stb, sect_ers_stb, susp_stb, resume_stb;
  logic [19:0] prog_addr;
  logic [7:0]  prog_data;
  logic [3:0]  ers_sector;
  logic [2:0]  mode;

  int total = 0, bad = 0;
  int cnt [7];
  int base [7];

  always #10 clk = ~clk;

  flash_cmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .data(data), .eng_busy(eng_busy), .eng_done(eng_done),
    .rst_stb(rst_stb), .id_stb(id_stb), .prog_stb(prog_stb), .chip_ers_stb(chip_ers_stb),
    .sect_ers_stb(sect_ers_stb), .susp_stb(susp_stb), .resume_stb(resume_stb),
    .prog_addr(prog_addr), .prog_data(prog_data), .ers_sector(ers_sector), .mode(mode)
  );

  initial for (int i = 0; i < 7; i++) cnt[i] = 0;

  always @(negedge clk) begin
    if (rst_stb)      cnt[0]++;
    if (id_stb)       cnt[1]++;
    if (prog_stb)     cnt[2]++;
    if (chip_ers_stb) cnt[3]++;
    if (sect_ers_stb) cnt[4]++;
    if (susp_stb)     cnt[5]++;
    if (resume_stb)   cnt[6]++;
  end

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic snap();
    for (int i = 0; i < 7; i++) base[i] = cnt[i];
  endtask

  task automatic strobes(input string req, input int r, input int i, input int p,
                         input int c, input int s, input int su, input int re);
    int e [7];
    e[0] = r; e[1] = i; e[2] = p; e[3] = c; e[4] = s; e[5] = su; e[6] = re;
    for (int k = 0; k < 7; k++)
      chk($sformatf("%s strobe%0d", req, k), cnt[k] - base[k], e[k]);
    snap();
  endtask

  task automatic wr(input logic [19:0] a, input logic [7:0] d, input logic oe = 1'b1);
    @(negedge clk);
    addr = a; data = d; oe_n = oe; ce_n = 1'b0; we_n = 1'b0;
    repeat (2) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic unlock(input logic [19:0] hi = 20'h0);
    wr(hi | 20'h555, 8'hAA);
    wr(hi | 20'h2AA, 8'h55);
  endtask

  task automatic done_pulse();
    @(negedge clk); eng_done = 1'b1;
    @(negedge clk); eng_done = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    chk("R1 mode", mode, 0);
    chk("R1 strobes", {rst_stb, id_stb, prog_stb, chip_ers_stb, sect_ers_stb, susp_stb, resume_stb}, 0);
  endtask

  task automatic t_id_and_reset();
    snap();
    unlock(20'hF8000);                   // R3 upper bits ignored
    wr(20'h7D555, 8'h90);
    strobes("R5 id", 0, 1, 0, 0, 0, 0, 0);
    chk("R5 mode id", mode, 1);
    wr(20'h12345, 8'hF0);
    strobes("R4 single reset", 1, 0, 0, 0, 0, 0, 0);
    chk("R4 mode", mode, 0);
    unlock(); wr(20'h555, 8'h90);
    wr(20'h00100, 8'h12);                // R8 mismatch leaves id mode
    strobes("R8 id then bad", 0, 1, 0, 0, 0, 0, 0);
    chk("R8 mode", mode, 0);
    wr(20'h555, 8'hAA); wr(20'h2AA, 8'hF0);   // R4 reset mid sequence
    strobes("R4 mid reset", 1, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_program();
    snap();
    unlock(); wr(20'h555, 8'hA0);
    wr(20'h31234, 8'h5A);
    strobes("R6 program", 0, 0, 1, 0, 0, 0, 0);
    chk("R6 addr", prog_addr, 20'h31234);
    chk("R6 data", prog_data, 8'h5A);
    chk("R6 mode", mode, 2);
    wr(20'h00000, 8'hF0);
    unlock(); wr(20'h555, 8'h90);
    strobes("R9 ignored", 0, 0, 0, 0, 0, 0, 0);
    chk("R9 mode held", mode, 2);
    done_pulse();
    chk("R9 done", mode, 0);
  endtask

  task automatic t_bad_sequence();
    snap();
    wr(20'h555, 8'hAA); wr(20'h2AB, 8'h55); wr(20'h555, 8'h90);
    strobes("R3 bad addr", 0, 0, 0, 0, 0, 0, 0);
    chk("R8 mode", mode, 0);
    wr(20'h555, 8'hAA, 1'b0);            // R2 oe low: not a write
    wr(20'h2AA, 8'h55); wr(20'h555, 8'h90);
    strobes("R2 oe gate", 0, 0, 0, 0, 0, 0, 0);
    wr(20'h00000, 8'h30); wr(20'h00000, 8'hB0);
    strobes("R8 lone resume/suspend", 0, 0, 0, 0, 0, 0, 0);
    chk("R8 mode", mode, 0);
  endtask

  task automatic t_chip_erase();
    snap();
    unlock(); wr(20'h555, 8'h80); unlock(); wr(20'h555, 8'h10);
    strobes("R7 chip", 0, 0, 0, 1, 0, 0, 0);
    chk("R7 mode", mode, 3);
    wr(20'h00000, 8'hB0);
    strobes("R10 chip no suspend", 0, 0, 0, 0, 0, 0, 0);
    chk("R10 mode", mode, 3);
    done_pulse();
    chk("R10 done", mode, 0);
  endtask

  task automatic t_sector_suspend();
    snap();
    unlock(); wr(20'h555, 8'h80); unlock(); wr(20'hA1234, 8'h30);
    strobes("R7 sector", 0, 0, 0, 0, 1, 0, 0);
    chk("R7 sector idx", ers_sector, 4'hA);
    chk("R7 mode", mode, 3);
    wr(20'h00000, 8'hF0);
    strobes("R10 reset ignored", 0, 0, 0, 0, 0, 0, 0);
    wr(20'h4ABCD, 8'hB0);
    strobes("R10 suspend", 0, 0, 0, 0, 0, 1, 0);
    chk("R10 mode", mode, 4);
    unlock(); wr(20'h555, 8'h90);
    strobes("R11 id blocked", 0, 0, 0, 0, 0, 0, 0);
    chk("R11 mode", mode, 4);
    unlock(); wr(20'h555, 8'hA0); wr(20'h20010, 8'hC3);
    strobes("R11 prog in suspend", 0, 0, 1, 0, 0, 0, 0);
    chk("R6 mode 5", mode, 5);
    chk("R6 data", prog_data, 8'hC3);
    wr(20'h00000, 8'h30);
    strobes("R9 ignored in 5", 0, 0, 0, 0, 0, 0, 0);
    done_pulse();
    chk("R9 back to suspend", mode, 4);
    wr(20'h00000, 8'h30);
    strobes("R11 resume", 0, 0, 0, 0, 0, 0, 1);
    chk("R11 mode", mode, 3);
    wr(20'h00000, 8'hB0);
    strobes("R11 suspend again", 0, 0, 0, 0, 0, 1, 0);
    eng_busy = 1'b1;
    wr(20'h00000, 8'h30);
    strobes("R13 resume busy", 0, 0, 0, 0, 0, 0, 0);
    chk("R13 mode", mode, 4);
    eng_busy = 1'b0;
    wr(20'h00000, 8'h30);
    strobes("R11 resume2", 0, 0, 0, 0, 0, 0, 1);
    done_pulse();
    chk("R10 done", mode, 0);
  endtask

  task automatic t_busy_block();
    snap();
    eng_busy = 1'b1;
    unlock(); wr(20'h555, 8'hA0); wr(20'h00042, 8'h11);
    strobes("R13 prog busy", 0, 0, 0, 0, 0, 0, 0);
    chk("R13 mode", mode, 0);
    eng_busy = 1'b0;
  endtask

  initial begin
    snap();
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset_state();
    t_id_and_reset();
    t_program();
    t_bad_sequence();
    t_chip_erase();
    t_sector_suspend();
    t_busy_block();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule